// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block holds the software-visible control state of a two-channel disk bus-master DMA controller. A small 16-byte register window is split into two 8-byte channel slices. Each slice carries a command byte, a status byte and a 32-bit descriptor-table base address. The command byte starts or stops a channel and sets its transfer direction. The table base tells the transfer engine where the descriptor list lives. The transfer engine itself sits outside this block.

The register bus is 32 bits wide. A word index selects one of four dwords in the window, and four byte enables select the lanes of that dword. Lane k is byte offset k inside the dword. Word index 2*c is the command/status dword of channel c, and word index 2*c+1 is its table-address dword. Writes take effect on the clock edge at which `reg_wr` is sampled. Read data is registered and appears on the cycle after `reg_rd`.

The status byte mixes three kinds of bit:

- bit 0 (active) is owned by hardware;
- bits 2 and 1 (interrupt and error) are write-one-to-clear, and are set by per-channel pulse inputs;
- bits 6 and 5 are plain storage.

The command/status dword honours only byte-wide accesses.

Top module: `busmaster_regs`

## Requirements
- R1: Word index 0 and 1 address channel 0 (command/status dword, then table dword); word index 2 and 3 address channel 1. A write to one channel never changes the other channel's registers or outputs.
- R2: In a command/status dword, a single-lane read of lane 1 or lane 3 returns 0xFF in that lane; lane 0 returns the command byte and lane 2 the status byte.
- R3: An access to a command/status dword whose byte enables are not exactly one-hot is ignored on write and returns 0xFF in every enabled lane on read.
- R4: A status write loads status bits 6 and 5 from the written data.
- R5: A status write leaves status bit 0 unchanged. A command write with bit 0 set makes status bit 0 one, and a command write with bit 0 clear makes it zero.
- R6: Writing 1 to status bit 2 or bit 1 clears that bit; writing 0 leaves it unchanged.
- R7: Status bits 7, 4 and 3 always read zero.
- R8: Command bit 0 (start) and bit 3 (direction) are read/write and drive `dma_start` and `dma_dir` of that channel; other command bits read zero.
- R9: A pulse on `err_set[c]` sets status bit 1 and a pulse on `irq_set[c]` sets status bit 2 of channel c. When a set and a write-one-to-clear hit the same cycle, the bit ends up set.
- R10: The table-address register takes byte-lane writes, drives `table_base`, and always holds zero in its two low bits.
- R11: A synchronous active-low reset clears command, status and table registers of both channels, so all outputs read zero.
- R12: Read data appears on `reg_rdata` one cycle after `reg_rd`; lanes whose enable is low read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 2 | Dword index within the window |
| reg_be | input | 4 | Byte-lane enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| err_set | input | 2 | Per-channel pulse setting status bit 1 |
| irq_set | input | 2 | Per-channel pulse setting status bit 2 |
| dma_start | output | 2 | Per-channel start bit |
| dma_dir | output | 2 | Per-channel direction bit |
| table_base | output | 64 | Per-channel table base, channel c in bits 32c+31:32c |

## Verification
Register writes and set pulses land on the rising edge at which they are sampled. Their effect is therefore due on `dma_start`, `dma_dir`, `table_base` and the stored bytes one edge later. A read issued in one cycle returns its data after the next rising edge. The bench drives every stimulus on a falling edge and deasserts it on the following falling edge. It samples the outputs at that second falling edge, when exactly one rising edge has passed. For a same-cycle set-versus-clear, the pulse and the write are driven in the same half period, so both are sampled at one edge.

// File: rtl/bmr_pkg.sv
// Package: shared constants and helpers for the bus-master register file.
// Assumes a 32-bit register bus split into four byte lanes.
package bmr_pkg;
    localparam int LANES    = 4;
    localparam int DATA_W   = LANES * 8;
    // status bit positions
    localparam int ST_ACT   = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_IRQ   = 2;
    localparam int ST_SW_LO = 5;
    localparam int ST_SW_HI = 6;
    // command bit positions
    localparam int CMD_GO   = 0;
    localparam int CMD_DIR  = 3;

    typedef logic [7:0] byte_t;

    // True when exactly one lane is enabled
    function automatic logic one_lane(input logic [LANES-1:0] be);
        return $countones(be) == 1;
    endfunction
endpackage

// File: rtl/bmr_decode.sv
// Module: bmr_decode
// Turns a register-bus write into per-channel write enables.
// Assumes word index = 2*channel + (0: command/status, 1: table address).
// Command/status writes are honoured only with exactly one lane enabled.
module bmr_decode
    import bmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int IDX_W = $clog2(2 * NUM_CH)
) (
    input  logic                    reg_wr,
    input  logic [IDX_W-1:0]        reg_idx,
    input  logic [LANES-1:0]        reg_be,
    output logic [NUM_CH-1:0]       cmd_we,
    output logic [NUM_CH-1:0]       st_we,
    output logic [NUM_CH*LANES-1:0] tbl_we
);
    logic single;
    logic tbl_word;

    // Classify the access once for all channels
    always_comb begin
        single   = one_lane(reg_be);
        tbl_word = reg_idx[0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        // Channel select and per-register enables
        always_comb begin
            hit       = reg_wr && (int'(reg_idx[IDX_W-1:1]) == c);
            cmd_we[c] = hit && !tbl_word && single && reg_be[0];
            st_we[c]  = hit && !tbl_word && single && reg_be[2];
            tbl_we[c*LANES +: LANES] = (hit && tbl_word) ? reg_be : '0;
        end
    end
endmodule

// File: rtl/bmr_channel.sv
// Module: bmr_channel
// One channel's command, status and table-address registers.
// Assumes enables are already decoded; sets from hardware beat clears.
module bmr_channel
    import bmr_pkg::*;
#(
    parameter int TBL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              st_we,
    input  logic [LANES-1:0]  tbl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_set,
    input  logic              irq_set,
    output byte_t             cmd_q,
    output byte_t             st_q,
    output logic [TBL_W-1:0]  tbl_q
);
    byte_t cmd_wr_byte;
    byte_t st_wr_byte;
    logic  go_q;
    logic  dir_q;
    logic  act_q;
    logic  err_q;
    logic  irq_q;
    logic  [1:0] sw_q;

    // Lane extraction for the byte registers
    always_comb begin
        cmd_wr_byte = wdata[7:0];
        st_wr_byte  = wdata[23:16];
    end

    // Command bits and the active flag they control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
            act_q <= 1'b0;
        end else if (cmd_we) begin
            go_q  <= cmd_wr_byte[CMD_GO];
            dir_q <= cmd_wr_byte[CMD_DIR];
            act_q <= cmd_wr_byte[CMD_GO];
        end
    end

    // Status storage: plain bits and write-one-to-clear flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q  <= '0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (st_we)
                sw_q <= st_wr_byte[ST_SW_HI:ST_SW_LO];
            err_q <= err_set | (err_q & ~(st_we & st_wr_byte[ST_ERR]));
            irq_q <= irq_set | (irq_q & ~(st_we & st_wr_byte[ST_IRQ]));
        end
    end

    // Table base, byte-lane writable, low two bits held at zero
    for (genvar l = 0; l < TBL_W / 8; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_q[l*8 +: 8] <= '0;
            else if (tbl_we[l])
                tbl_q[l*8 +: 8] <= (l == 0) ? (wdata[7:0] & 8'hFC)
                                            : wdata[l*8 +: 8];
        end
    end

    // Assemble readable bytes
    always_comb begin
        cmd_q = '0;
        cmd_q[CMD_GO]  = go_q;
        cmd_q[CMD_DIR] = dir_q;
        st_q = '0;
        st_q[ST_ACT] = act_q;
        st_q[ST_ERR] = err_q;
        st_q[ST_IRQ] = irq_q;
        st_q[ST_SW_HI:ST_SW_LO] = sw_q;
    end

    AST_ACT_FOLLOWS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> st_q[ST_ACT] == $past(wdata[CMD_GO])); // R5
    AST_ACT_KEPT_ON_ST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !cmd_we) |=> $stable(st_q[ST_ACT])); // R5
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> st_q[ST_ERR]); // R9
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> st_q[ST_IRQ]); // R9
    AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && wdata[16 + ST_ERR] && !err_set) |=> !st_q[ST_ERR]); // R6
    AST_TBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we == '0) |=> $stable(tbl_q)); // R10
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q)); // R3
endmodule

// File: rtl/bmr_readmux.sv
// Module: bmr_readmux
// Combinational read-data selection for the register window.
// Assumes the caller registers the result; disabled lanes return zero.
module bmr_readmux
    import bmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TBL_W  = 32,
    localparam int IDX_W = $clog2(2 * NUM_CH)
) (
    input  logic [IDX_W-1:0]        reg_idx,
    input  logic [LANES-1:0]        reg_be,
    input  logic [NUM_CH*8-1:0]     cmd_all,
    input  logic [NUM_CH*8-1:0]     st_all,
    input  logic [NUM_CH*TBL_W-1:0] tbl_all,
    output logic [DATA_W-1:0]       rd_data
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] lane_mask;

    // Choose the dword image, then mask by lane enables
    always_comb begin
        raw = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(reg_idx[IDX_W-1:1]) == c) begin
                if (reg_idx[0])
                    raw = tbl_all[c*TBL_W +: TBL_W];
                else if (one_lane(reg_be))
                    raw = {8'hFF, st_all[c*8 +: 8], 8'hFF, cmd_all[c*8 +: 8]};
                else
                    raw = '1;
            end
        end
        for (int l = 0; l < LANES; l++)
            lane_mask[l*8 +: 8] = {8{reg_be[l]}};
        rd_data = raw & lane_mask;
    end
endmodule

// File: rtl/busmaster_regs.sv
// Module: busmaster_regs (top)
// Register file for a two-channel bus-master DMA controller: decode,
// per-channel registers and a registered read port.
// Assumes a single-cycle write strobe and one-cycle read latency.
module busmaster_regs
    import bmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TBL_W  = 32,
    localparam int IDX_W = $clog2(2 * NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [IDX_W-1:0]        reg_idx,
    input  logic [LANES-1:0]        reg_be,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic [NUM_CH-1:0]       err_set,
    input  logic [NUM_CH-1:0]       irq_set,
    output logic [NUM_CH-1:0]       dma_start,
    output logic [NUM_CH-1:0]       dma_dir,
    output logic [NUM_CH*TBL_W-1:0] table_base
);
    logic [NUM_CH-1:0]       cmd_we;
    logic [NUM_CH-1:0]       st_we;
    logic [NUM_CH*LANES-1:0] tbl_we;
    logic [NUM_CH*8-1:0]     cmd_all;
    logic [NUM_CH*8-1:0]     st_all;
    logic [DATA_W-1:0]       rd_next;

    bmr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .reg_wr (reg_wr),
        .reg_idx(reg_idx),
        .reg_be (reg_be),
        .cmd_we (cmd_we),
        .st_we  (st_we),
        .tbl_we (tbl_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        bmr_channel #(.TBL_W(TBL_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_we (cmd_we[c]),
            .st_we  (st_we[c]),
            .tbl_we (tbl_we[c*LANES +: LANES]),
            .wdata  (reg_wdata),
            .err_set(err_set[c]),
            .irq_set(irq_set[c]),
            .cmd_q  (cmd_all[c*8 +: 8]),
            .st_q   (st_all[c*8 +: 8]),
            .tbl_q  (table_base[c*TBL_W +: TBL_W])
        );
        // Per-channel control outputs
        always_comb begin
            dma_start[c] = cmd_all[c*8 + CMD_GO];
            dma_dir[c]   = cmd_all[c*8 + CMD_DIR];
        end
    end

    bmr_readmux #(.NUM_CH(NUM_CH), .TBL_W(TBL_W)) u_rmux (
        .reg_idx(reg_idx),
        .reg_be (reg_be),
        .cmd_all(cmd_all),
        .st_all (st_all),
        .tbl_all(table_base),
        .rd_data(rd_next)
    );

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_next;
    end

    AST_PAD_LANE_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_idx[0] && reg_be == 4'b0010) |=> reg_rdata == 32'h0000_FF00); // R2
    AST_WIDE_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_idx[0] && reg_be == 4'b1111) |=> reg_rdata == 32'hFFFF_FFFF); // R3
    AST_ZERO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_be == 4'b0000) |=> reg_rdata == '0); // R12
endmodule

// File: tb/busmaster_regs_test.sv
// Directed bench for busmaster_regs; each task checks its own results.
module busmaster_regs_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_idx;
    logic [3:0]  reg_be;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  err_set, irq_set;
    logic [1:0]  dma_start, dma_dir;
    logic [63:0] table_base;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    busmaster_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .err_set(err_set), .irq_set(irq_set),
        .dma_start(dma_start), .dma_dir(dma_dir), .table_base(table_base)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx; reg_be = be;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] st_lane(input logic [7:0] b);
        return {8'h00, b, 16'h0000};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, 4'b0001, d); chk("R11 cmd0", d, 0);
        rd(2'd0, 4'b0100, d); chk("R11 st0", d, 0);
        rd(2'd3, 4'b1111, d); chk("R11 tbl1", d, 0);
        chk("R11 outputs", {dma_start, dma_dir, table_base}, 0);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        wr(2'd0, 4'b0001, 32'h0000_00FF);
        chk("R8 start/dir out", {dma_start, dma_dir}, 4'b0101);
        rd(2'd0, 4'b0001, d); chk("R8 cmd readback", d, 32'h09);
        rd(2'd0, 4'b0100, d); chk("R5 active set by start", d, st_lane(8'h01));
        rd(2'd2, 4'b0001, d); chk("R1 ch1 cmd untouched", d, 0);
    endtask

    task automatic t_status_rw();
        logic [31:0] d;
        wr(2'd0, 4'b0100, 32'h00FE_0000);
        rd(2'd0, 4'b0100, d); chk("R4 R7 R5 status 0xFE write", d, st_lane(8'h61));
        wr(2'd0, 4'b0100, 32'h0000_0000);
        rd(2'd0, 4'b0100, d); chk("R4 status cleared rw bits", d, st_lane(8'h01));
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        @(negedge clk); err_set = 2'b10;
        @(negedge clk); err_set = 2'b00; irq_set = 2'b10;
        @(negedge clk); irq_set = 2'b00;
        rd(2'd2, 4'b0100, d); chk("R9 hw set ch1", d, st_lane(8'h06));
        rd(2'd0, 4'b0100, d); chk("R1 ch0 status untouched", d, st_lane(8'h01));
        wr(2'd2, 4'b0100, 32'h0002_0000);
        rd(2'd2, 4'b0100, d); chk("R6 clear err", d, st_lane(8'h04));
        wr(2'd2, 4'b0100, 32'h0000_0000);
        rd(2'd2, 4'b0100, d); chk("R6 zero keeps", d, st_lane(8'h04));
        // set and clear in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 2'd2; reg_be = 4'b0100; reg_wdata = 32'h0004_0000;
        irq_set = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0; irq_set = 2'b00;
        rd(2'd2, 4'b0100, d); chk("R9 set wins", d, st_lane(8'h04));
        wr(2'd2, 4'b0100, 32'h0004_0000);
        rd(2'd2, 4'b0100, d); chk("R6 clear irq", d, 0);
    endtask

    task automatic t_pad();
        logic [31:0] d;
        rd(2'd0, 4'b0010, d); chk("R2 lane1", d, 32'h0000_FF00);
        rd(2'd2, 4'b1000, d); chk("R2 lane3", d, 32'hFF00_0000);
    endtask

    task automatic t_wide();
        logic [31:0] d;
        wr(2'd0, 4'b0011, 32'h0000_0000);
        chk("R3 wide write ignored", {dma_start[0], dma_dir[0]}, 2'b11);
        wr(2'd0, 4'b1100, 32'h0007_0000);
        rd(2'd0, 4'b0100, d); chk("R3 wide status write ignored", d, st_lane(8'h01));
        rd(2'd0, 4'b1111, d); chk("R3 wide read", d, 32'hFFFF_FFFF);
        rd(2'd2, 4'b0011, d); chk("R3 half read", d, 32'h0000_FFFF);
    endtask

    task automatic t_table();
        logic [31:0] d;
        wr(2'd1, 4'b1111, 32'h1234_5677);
        rd(2'd1, 4'b1111, d); chk("R10 aligned", d, 32'h1234_5674);
        wr(2'd1, 4'b0100, 32'h00AB_0000);
        chk("R10 lane write", table_base[31:0], 32'h12AB_5674);
        wr(2'd3, 4'b1111, 32'hDEAD_BEEF);
        chk("R1 R10 ch1 table", table_base, 64'hDEAD_BEEC_12AB_5674);
        rd(2'd1, 4'b0001, d); chk("R12 masked lanes", d, 32'h0000_0074);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(2'd0, 4'b0001, 32'h0000_0008);
        chk("R8 stop", {dma_start, dma_dir}, 4'b0001);
        rd(2'd0, 4'b0100, d); chk("R5 active cleared", d, 0);
    endtask

    task automatic t_rereset();
        logic [31:0] d;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 re-reset outputs", {dma_start, dma_dir, table_base}, 0);
        rd(2'd1, 4'b1111, d); chk("R11 table cleared", d, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_idx = '0;
        reg_be = '0; reg_wdata = '0; err_set = '0; irq_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_status_rw();
        t_w1c();
        t_pad();
        t_wide();
        t_table();
        t_stop();
        t_rereset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule